// File: doc/BRIEF.md
# Indirect Wide Register Bridge

This block sits behind a 32-bit slave register port and reaches a bank of 64-bit registers through an internal request/acknowledge bus. The host never touches a 64-bit register directly. It stages a value in two 32-bit data windows, or collects a value from them. The access itself starts when the host writes a command word, whose top bit picks the direction.

A write command sends the staged 64-bit value to the internal bus. A read command fills the upper window with the upper half of the returned value and the lower window with the lower half. Command addresses are absolute. The bank occupies an aligned window that starts at a base address, so the bridge subtracts the base and rejects any address outside the window.

The status word shows a busy flag while an access is outstanding. It also shows a sticky error flag, which is set by an error response, by a missing acknowledge or by a rejected address. Writing any value to the reset word clears the error flag and abandons an outstanding access.

Top module: `wide_reg_bridge`

## Requirements
- R1: After reset, both data windows and the status word read 0 and `bus_req` is low.
- R2: Host writes to offset 0x00 load the upper window and to 0x04 the lower window; reads return them, while offsets 0x08, 0x18 and every unmapped offset read 0.
- R3: A write to offset 0x08 with bit 31 set starts a write: from the next cycle `bus_req`=1, `bus_we`=1, `bus_wdata`={upper window, lower window}, `bus_addr`=bits 30:0 of the command minus WIN_BASE.
- R4: A write to offset 0x08 with bit 31 clear starts a read with `bus_we`=0; on the acknowledge edge the upper window takes `bus_rdata[63:32]` and the lower window takes `bus_rdata[31:0]`.
- R5: Status bit 0 (offset 0x1C) is 1 from the cycle after the command write until the cycle after the access ends; `bus_req` is held over the same span.
- R6: An `bus_err` response ends the access, sets status bit 31 and leaves both windows unchanged.
- R7: When no `bus_ack` or `bus_err` arrives on any of the TIMEOUT edges that follow the command, `bus_req` drops after the TIMEOUT-th edge and status bit 31 is set; a later acknowledge has no effect.
- R8: A command address outside [WIN_BASE, WIN_BASE + 2^BAW) raises no request and sets status bit 31 at the command edge.
- R9: A write of any value to offset 0x18 clears status bit 31 and drops an outstanding request; a later acknowledge leaves the windows unchanged.
- R10: While busy, host writes to the windows and to the command word are ignored, and window reads return the values held before the access.
- R11: Status bit 31 stays set through later accesses, including successful ones, until the reset word is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_valid | input | 1 | Host access strobe, one cycle per access |
| hst_write | input | 1 | 1 = host write, 0 = host read |
| hst_addr | input | 5 | Host byte offset |
| hst_wdata | input | 32 | Host write data |
| hst_rdata | output | 32 | Host read data, combinational on hst_addr |
| bus_req | output | 1 | Internal access request, held until it ends |
| bus_we | output | 1 | Internal access direction, 1 = write |
| bus_addr | output | BAW | Register offset inside the bank |
| bus_wdata | output | 64 | Internal write data |
| bus_rdata | input | 64 | Internal read data, valid with bus_ack |
| bus_ack | input | 1 | Successful completion |
| bus_err | input | 1 | Failed completion |

## Verification
The bench builds the bridge with TIMEOUT=8 and BAW=4, so the bank window is only 16 words wide. This makes exhaustive sweeps practical. One sweep covers every response delay from the first edge to two edges past the timeout, for both acknowledge and error responses. The other covers every command address from just below the window base to just past its top end. Expected window contents, status words and bus offsets are computed arithmetically from the delay and the address.

// File: rtl/wide_reg_bridge_pkg.sv
// Package: host register map and shared widths for the wide register bridge.
// Assumes a 32-bit host port and 64-bit internal registers.
package wide_reg_bridge_pkg;
    localparam int HOST_AW = 5;
    localparam int HOST_DW = 32;
    localparam int WIDE_DW = 2 * HOST_DW;

    localparam logic [HOST_AW-1:0] OFS_WIN_HI = 5'h00;
    localparam logic [HOST_AW-1:0] OFS_WIN_LO = 5'h04;
    localparam logic [HOST_AW-1:0] OFS_CMD    = 5'h08;
    localparam logic [HOST_AW-1:0] OFS_RST    = 5'h18;
    localparam logic [HOST_AW-1:0] OFS_STAT   = 5'h1C;

    localparam int CMD_DIR_BIT  = 31;
    localparam int STAT_ERR_BIT = 31;
    localparam int STAT_BSY_BIT = 0;
endpackage

// File: rtl/wide_reg_bridge_host.sv
// Host-side register file: decodes host accesses, stages the two data
// windows, keeps the sticky error flag and forms the status word.
// Assumes one host access per hst_valid cycle; reads are combinational.
module wide_reg_bridge_host
    import wide_reg_bridge_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_valid,
    input  logic               hst_write,
    input  logic [HOST_AW-1:0] hst_addr,
    input  logic [HOST_DW-1:0] hst_wdata,
    output logic [HOST_DW-1:0] hst_rdata,
    input  logic               busy_i,
    input  logic               cap_i,
    input  logic [WIDE_DW-1:0] cap_data_i,
    input  logic               fail_i,
    output logic               start_o,
    output logic               clr_o,
    output logic [WIDE_DW-1:0] stage_o
);
    logic [HOST_DW-1:0] win_hi_q;
    logic [HOST_DW-1:0] win_lo_q;
    logic               err_q;
    logic               wr_acc;

    assign wr_acc  = hst_valid && hst_write;
    assign start_o = wr_acc && (hst_addr == OFS_CMD) && !busy_i;
    assign clr_o   = wr_acc && (hst_addr == OFS_RST);
    assign stage_o = {win_hi_q, win_lo_q};

    // Data windows: host staging when idle, capture of read data on completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_hi_q <= '0;
            win_lo_q <= '0;
        end else if (cap_i) begin
            win_hi_q <= cap_data_i[WIDE_DW-1:HOST_DW];
            win_lo_q <= cap_data_i[HOST_DW-1:0];
        end else if (wr_acc && !busy_i) begin
            if (hst_addr == OFS_WIN_HI) win_hi_q <= hst_wdata;
            if (hst_addr == OFS_WIN_LO) win_lo_q <= hst_wdata;
        end
    end

    // Sticky error flag: the reset word clears it and takes priority over a new failure.
    always_ff @(posedge clk) begin
        if (!rst_n)      err_q <= 1'b0;
        else if (clr_o)  err_q <= 1'b0;
        else if (fail_i) err_q <= 1'b1;
    end

    // Host read multiplexer.
    always_comb begin
        hst_rdata = '0;
        case (hst_addr)
            OFS_WIN_HI: hst_rdata = win_hi_q;
            OFS_WIN_LO: hst_rdata = win_lo_q;
            OFS_STAT: begin
                hst_rdata[STAT_ERR_BIT] = err_q;
                hst_rdata[STAT_BSY_BIT] = busy_i;
            end
            default: hst_rdata = '0;
        endcase
    end

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_q && !clr_o |=> err_q); // R11
    AST_WIN_HOLD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i && !cap_i |=> $stable(win_hi_q) && $stable(win_lo_q)); // R10
endmodule

// File: rtl/wide_reg_bridge_engine.sv
// Access engine: checks the command address against the bank window,
// holds the internal request, counts the acknowledge timeout and reports
// the outcome. Assumes start_i never arrives while an access is pending.
module wide_reg_bridge_engine
    import wide_reg_bridge_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'h0007_0000,
    parameter int          BAW      = 16,
    parameter int          TIMEOUT  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic               abort_i,
    input  logic [HOST_DW-1:0] cmd_i,
    input  logic [WIDE_DW-1:0] stage_i,
    output logic               busy_o,
    output logic               cap_o,
    output logic [WIDE_DW-1:0] cap_data_o,
    output logic               fail_o,
    output logic               bus_req,
    output logic               bus_we,
    output logic [BAW-1:0]     bus_addr,
    output logic [WIDE_DW-1:0] bus_wdata,
    input  logic [WIDE_DW-1:0] bus_rdata,
    input  logic               bus_ack,
    input  logic               bus_err
);
    localparam int             CW   = $clog2(TIMEOUT + 1);
    localparam logic [31:0]    SPAN = 32'd1 << BAW;
    localparam logic [CW-1:0]  LAST = CW'(TIMEOUT - 1);

    logic               pend_q;
    logic [CW-1:0]      cnt_q;
    logic               we_q;
    logic [BAW-1:0]     addr_q;
    logic [WIDE_DW-1:0] wdata_q;
    logic [31:0]        abs_addr;
    logic [31:0]        rel_addr;
    logic               in_win;
    logic               expire;

    assign abs_addr = {1'b0, cmd_i[CMD_DIR_BIT-1:0]};
    assign rel_addr = abs_addr - WIN_BASE;
    assign in_win   = (abs_addr >= WIN_BASE) && (rel_addr < SPAN);
    assign expire   = pend_q && !bus_ack && !bus_err && (cnt_q == LAST);

    // Access state: launch, hold, finish on response, timeout or abort.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q  <= 1'b0;
            cnt_q   <= '0;
            we_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (abort_i) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (start_i && in_win) begin
            pend_q  <= 1'b1;
            cnt_q   <= '0;
            we_q    <= cmd_i[CMD_DIR_BIT];
            addr_q  <= rel_addr[BAW-1:0];
            wdata_q <= stage_i;
        end else if (pend_q && (bus_ack || bus_err || expire)) begin
            pend_q <= 1'b0;
            cnt_q  <= '0;
        end else if (pend_q) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Outcome decode towards the host register file.
    always_comb begin
        cap_o      = pend_q && bus_ack && !bus_err && !we_q && !abort_i;
        cap_data_o = bus_rdata;
        fail_o     = !abort_i && ((start_i && !in_win) ||
                                  (pend_q && bus_err) || expire);
    end

    assign busy_o    = pend_q;
    assign bus_req   = pend_q;
    assign bus_we    = we_q;
    assign bus_addr  = addr_q;
    assign bus_wdata = wdata_q;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < CW'(TIMEOUT)); // R7
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ack && !bus_err && !abort_i && (cnt_q != LAST) |=> bus_req); // R5
    AST_REJECT_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        start_i && !in_win && !bus_req |=> !bus_req); // R8
    AST_ABORT_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        abort_i |=> !bus_req); // R9
    AST_STABLE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && $past(bus_req) |-> $stable(bus_addr) && $stable(bus_we)
                                      && $stable(bus_wdata)); // R3
endmodule

// File: rtl/wide_reg_bridge.sv
// Top level: 32-bit host port giving indirect access to 64-bit registers
// over an internal request/acknowledge bus. Connects the host register
// file to the access engine.
module wide_reg_bridge
    import wide_reg_bridge_pkg::*;
#(
    parameter logic [31:0] WIN_BASE = 32'h0007_0000,
    parameter int          BAW      = 16,
    parameter int          TIMEOUT  = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               hst_valid,
    input  logic               hst_write,
    input  logic [HOST_AW-1:0] hst_addr,
    input  logic [HOST_DW-1:0] hst_wdata,
    output logic [HOST_DW-1:0] hst_rdata,
    output logic               bus_req,
    output logic               bus_we,
    output logic [BAW-1:0]     bus_addr,
    output logic [WIDE_DW-1:0] bus_wdata,
    input  logic [WIDE_DW-1:0] bus_rdata,
    input  logic               bus_ack,
    input  logic               bus_err
);
    logic               busy;
    logic               cap;
    logic [WIDE_DW-1:0] cap_data;
    logic               fail;
    logic               start;
    logic               clr;
    logic [WIDE_DW-1:0] stage;

    wide_reg_bridge_host host_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .hst_valid  (hst_valid),
        .hst_write  (hst_write),
        .hst_addr   (hst_addr),
        .hst_wdata  (hst_wdata),
        .hst_rdata  (hst_rdata),
        .busy_i     (busy),
        .cap_i      (cap),
        .cap_data_i (cap_data),
        .fail_i     (fail),
        .start_o    (start),
        .clr_o      (clr),
        .stage_o    (stage)
    );

    wide_reg_bridge_engine #(
        .WIN_BASE (WIN_BASE),
        .BAW      (BAW),
        .TIMEOUT  (TIMEOUT)
    ) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .abort_i    (clr),
        .cmd_i      (hst_wdata),
        .stage_i    (stage),
        .busy_o     (busy),
        .cap_o      (cap),
        .cap_data_o (cap_data),
        .fail_o     (fail),
        .bus_req    (bus_req),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .bus_ack    (bus_ack),
        .bus_err    (bus_err)
    );

    AST_REQ_AFTER_CMD: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(hst_valid && hst_write && hst_addr == OFS_CMD)); // R3
endmodule

// File: tb/wide_reg_bridge_tb_top.sv
module wide_reg_bridge_tb_top;
    localparam logic [31:0] BASE = 32'h0007_0000;
    localparam int BAW = 4;
    localparam int TO  = 8;
    localparam logic [31:0] ERRW = 32'h8000_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hst_valid = 1'b0;
    logic        hst_write = 1'b0;
    logic [4:0]  hst_addr = '0;
    logic [31:0] hst_wdata = '0;
    logic [31:0] hst_rdata;
    logic        bus_req;
    logic        bus_we;
    logic [BAW-1:0] bus_addr;
    logic [63:0] bus_wdata;
    logic [63:0] bus_rdata = '0;
    logic        bus_ack = 1'b0;
    logic        bus_err = 1'b0;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    wide_reg_bridge #(.WIN_BASE(BASE), .BAW(BAW), .TIMEOUT(TO)) dut_i (
        .clk(clk), .rst_n(rst_n), .hst_valid(hst_valid), .hst_write(hst_write),
        .hst_addr(hst_addr), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .bus_err(bus_err)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic hwrite(input logic [4:0] a, input logic [31:0] d);
        hst_valid = 1'b1; hst_write = 1'b1; hst_addr = a; hst_wdata = d;
        @(posedge clk);
        @(negedge clk);
        hst_valid = 1'b0; hst_write = 1'b0;
    endtask

    task automatic hread(input logic [4:0] a, output logic [31:0] d);
        hst_addr = a;
        #1;
        d = hst_rdata;
    endtask

    // Drive a response so that it is sampled on the k-th edge after the command.
    task automatic respond(input int k, input bit is_err, input logic [63:0] d);
        repeat (k - 1) @(negedge clk);
        bus_rdata = d; bus_ack = !is_err; bus_err = is_err;
        @(negedge clk);
        bus_ack = 1'b0; bus_err = 1'b0;
    endtask

    initial begin
        #1500000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        hread(5'h00, r); check("R1 win_hi", r, 0);
        hread(5'h04, r); check("R1 win_lo", r, 0);
        hread(5'h1C, r); check("R1 status", r, 0);
        check("R1 req", bus_req, 0);

        // R2 window staging and unmapped reads
        hwrite(5'h00, 32'h1234_5678);
        hwrite(5'h04, 32'h9ABC_DEF0);
        hread(5'h00, r); check("R2 win_hi", r, 32'h1234_5678);
        hread(5'h04, r); check("R2 win_lo", r, 32'h9ABC_DEF0);
        for (int a = 8; a < 32; a += 4) begin
            if (a != 28) begin
                hread(5'(a), r); check("R2 unmapped", r, 0);
            end
        end

        // R3/R5/R8 write sweep over command addresses around the window
        for (int off = -3; off <= 18; off++) begin
            logic [31:0] hi;
            logic [31:0] adr;
            bit inw;
            hi  = 32'hA500_0000 + 32'(off + 3);
            adr = BASE + 32'(off);
            inw = (off >= 0) && (off < 16);
            hwrite(5'h18, 0);
            hwrite(5'h00, hi);
            hwrite(5'h04, ~hi);
            hwrite(5'h08, {1'b1, adr[30:0]});
            if (inw) begin
                check("R3 req", bus_req, 1);
                check("R3 we", bus_we, 1);
                check("R3 addr", 64'(bus_addr), 64'(off));
                check("R3 wdata", bus_wdata, {hi, ~hi});
                hread(5'h1C, r); check("R5 busy", r, 1);
                respond(1, 0, 64'h0);
                check("R5 req done", bus_req, 0);
                hread(5'h1C, r); check("R3 status", r, 0);
            end else begin
                check("R8 no req", bus_req, 0);
                hread(5'h1C, r); check("R8 status", r, ERRW);
            end
        end

        // R4/R6/R7 response delay sweep for ack and err
        for (int e = 0; e < 2; e++) begin
            for (int k = 1; k <= TO + 2; k++) begin
                logic [63:0] d;
                bit ok;
                d  = {32'h1000_0000 + 32'(k), 32'h2000_0000 + 32'(k + 16 * e)};
                ok = (e == 0) && (k <= TO);
                hwrite(5'h18, 0);
                hwrite(5'h00, 32'h0AAA_0000);
                hwrite(5'h04, 32'h0BBB_0000);
                hwrite(5'h08, BASE + 32'(k % 16));
                check("R4 we", bus_we, 0);
                check("R4 req", bus_req, 1);
                respond(k, e == 1, d);
                check("R7 req low", bus_req, 0);
                hread(5'h00, r); check(e ? "R6 win_hi" : "R4/R7 win_hi", r, ok ? d[63:32] : 32'h0AAA_0000);
                hread(5'h04, r); check(e ? "R6 win_lo" : "R4/R7 win_lo", r, ok ? d[31:0] : 32'h0BBB_0000);
                hread(5'h1C, r); check(e ? "R6 status" : "R7 status", r, ok ? 0 : ERRW);
            end
        end

        // R10 writes ignored and old values read while busy
        hwrite(5'h18, 0);
        hwrite(5'h00, 32'h0000_1111);
        hwrite(5'h04, 32'h0000_2222);
        hwrite(5'h08, BASE + 2);
        hwrite(5'h00, 32'hDEAD_BEEF);
        hread(5'h00, r); check("R10 win_hi busy", r, 32'h0000_1111);
        hwrite(5'h08, 32'h8000_0000 | (BASE + 5));
        check("R10 cmd ignored we", bus_we, 0);
        check("R10 cmd ignored addr", 64'(bus_addr), 2);
        respond(1, 0, 64'h0303_0303_0404_0404);
        check("R10 no second req", bus_req, 0);
        @(negedge clk);
        check("R10 no second req later", bus_req, 0);
        hread(5'h00, r); check("R10 win_hi after", r, 32'h0303_0303);

        // R9 reset word clears error and aborts pending access
        hwrite(5'h08, 32'h0000_0010);
        hread(5'h1C, r); check("R9 err set", r, ERRW);
        hwrite(5'h08, BASE + 1);
        check("R9 pending", bus_req, 1);
        hwrite(5'h18, 32'h5A5A_5A5A);
        check("R9 req dropped", bus_req, 0);
        hread(5'h1C, r); check("R9 status cleared", r, 0);
        respond(1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
        hread(5'h00, r); check("R9 late ack win_hi", r, 32'h0303_0303);
        hread(5'h04, r); check("R9 late ack win_lo", r, 32'h0404_0404);

        // R11 error sticky across a successful access
        hwrite(5'h08, 32'h7FFF_FFFF);
        hwrite(5'h08, BASE + 3);
        respond(2, 0, 64'h0505_0505_0606_0606);
        hread(5'h1C, r); check("R11 status sticky", r, ERRW);
        hread(5'h04, r); check("R11 data still captured", r, 32'h0606_0606);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule